// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block lets a CPU read and burn a one-time-programmable fuse array through a single-cycle register port. Software selects an operation in a command register, sets a row address and, for writes, one or two 32-bit data words. It then sets a start bit and polls a status register until the completion flag rises. Software clears the start bit before it issues the next operation. The fuse array is modelled inside the block as a flop array. Its bits can only go from 0 to 1, and each row holds `ROW_WORDS` words (1 or 2).

Burning is locked after reset. To unlock it, software selects the unlock command and issues four key words, each with its own start pulse. Once the key is accepted, a permission flag in the status register is set. A lock command clears that flag again. The time a burn takes is modelled as a fixed number of cycles per set bit in the data written.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the status register (0x0C), the mode register (0x00) and both read-data registers (0x10, 0x5C) read 0, and every fuse row reads back as 0.
- R2: While bit 0 of the mode register (0x00) is 0, writing 1 to the start bit launches nothing: the done flag (status bit 1) stays 0 and no row changes.
- R3: The address register (0x28) keeps only the low 16 bits written and the command register (0x04) keeps only the low 6 bits. Upper bits read back as 0.
- R4: An operation is launched only when bit 0 of the start register (0x08) is written to 1 while it holds 0. The done flag (status bit 1) rises when the operation ends, and it drops when the start bit is written to 0.
- R5: Command 0x02 (unlock) compares write-data word 0 (0x2C) with the next expected key word. The key words are 0xF, 0x4, 0x8 and 0xD, in that order. When all four are matched, the permission flag (status bit 2) rises. A mismatch returns the tracker to the first key word and is not itself counted. Each unlock step completes in 1 cycle.
- R6: Command 0x03 (lock) clears the permission flag. Command 0x08 (program) without permission completes in 1 cycle and leaves the array unchanged.
- R7: With permission, command 0x08 ORs the row's write-data words into the row at the address register. Bits already set stay set.
- R8: A permitted program completes 1 + `CYC_PER_BIT` × (number of 1 bits in the row's write data) cycles after the launching edge.
- R9: Command 0x00 (read) copies the addressed row into the read-data registers. Word 0 goes to 0x10 and word 1 to 0x5C. Done rises `READ_CYC` cycles after the launching edge.
- R10: With two-word rows, the second write word is written at 0x64 and the second read word is read at 0x5C. In a row, word w occupies bits [32w+31:32w].
- R11: The command, row and data are captured at launch. Writes to the data, address or start registers during a running operation change neither its result nor its timing, and they launch nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The operation in flight can complete in the very cycle in which the CPU rewrites the write-data register. The completion edge updates the array from the launch-time copy, while the register-file write lands on the same edge. The bench counts the set bits of a burn and places a write-data write exactly on its completion edge. The row read back must then hold the original data, and the done flag must be set at that very edge.

// File: rtl/otp_pkg.sv
package otp_pkg;

   localparam int WORD_W    = 32;
   localparam int CMD_W     = 6;
   localparam int ROWADDR_W = 16;
   localparam int BUS_AW    = 8;

   // register offsets (software-visible, behaviour depends on them)
   localparam logic [BUS_AW-1:0] OFS_MODE   = 8'h00;
   localparam logic [BUS_AW-1:0] OFS_CMD    = 8'h04;
   localparam logic [BUS_AW-1:0] OFS_START  = 8'h08;
   localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h0C;
   localparam logic [BUS_AW-1:0] OFS_ADDR   = 8'h28;
   localparam logic [BUS_AW-1:0] OFS_RD [2] = '{8'h10, 8'h5C};
   localparam logic [BUS_AW-1:0] OFS_WD [2] = '{8'h2C, 8'h64};

   // command codes
   localparam logic [CMD_W-1:0] OP_READ   = 6'h00;
   localparam logic [CMD_W-1:0] OP_UNLOCK = 6'h02;
   localparam logic [CMD_W-1:0] OP_LOCK   = 6'h03;
   localparam logic [CMD_W-1:0] OP_PROG   = 6'h08;

   // status bit positions
   localparam int ST_DONE = 1;
   localparam int ST_PERM = 2;

   // unlock key
   localparam int KEY_LEN = 4;
   function automatic logic [WORD_W-1:0] key_word(input logic [1:0] idx);
      case (idx)
         2'd0:    key_word = 32'h0000_000F;
         2'd1:    key_word = 32'h0000_0004;
         2'd2:    key_word = 32'h0000_0008;
         default: key_word = 32'h0000_000D;
      endcase
   endfunction

endpackage

// File: rtl/otp_key_tracker.sv
module otp_key_tracker
   import otp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              clr_en,
   input  logic [WORD_W-1:0] key_in,
   output logic              perm
);

   localparam int STEP_W = $clog2(KEY_LEN);

   logic [STEP_W-1:0] step_q;
   logic              perm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         perm_q <= 1'b0;
      end else if (clr_en) begin
         step_q <= '0;
         perm_q <= 1'b0;
      end else if (step_en) begin
         if (key_in == key_word(step_q)) begin
            if (step_q == STEP_W'(KEY_LEN - 1)) begin
               step_q <= '0;
               perm_q <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end else begin
            step_q <= '0;
         end
      end
   end

   assign perm = perm_q;

endmodule

// File: rtl/otp_op_timer.sv
module otp_op_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] load,
   output logic             busy,
   output logic             finish
);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch) begin
         busy_q <= 1'b1;
         cnt_q  <= load;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy   = busy_q;
   assign finish = busy_q && (cnt_q == '0);

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
   parameter int ROWS      = 16,
   parameter int ROW_WORDS = 2,
   localparam int WORD_W   = otp_pkg::WORD_W,
   localparam int ROW_BITS = ROW_WORDS * WORD_W,
   localparam int IDX_W    = $clog2(ROWS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [ROW_BITS-1:0]      wr_bits,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [ROW_BITS-1:0]      rd_bits,
   output logic [ROWS*ROW_BITS-1:0] all_bits
);

   logic [ROW_BITS-1:0] row_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               row_q[r][w*WORD_W +: WORD_W] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(r)))
               row_q[r][w*WORD_W +: WORD_W] <= row_q[r][w*WORD_W +: WORD_W]
                                             | wr_bits[w*WORD_W +: WORD_W];
         end
      end
      assign all_bits[r*ROW_BITS +: ROW_BITS] = row_q[r];
   end

   assign rd_bits = row_q[rd_idx];

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
   import otp_pkg::*;
#(
   parameter int ROWS        = 16,
   parameter int ROW_WORDS   = 2,
   parameter int CYC_PER_BIT = 2,
   parameter int READ_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam int ROW_BITS = ROW_WORDS * WORD_W;
   localparam int IDX_W    = $clog2(ROWS);
   localparam int POP_W    = $clog2(ROW_BITS + 1);
   localparam int CNT_W    = $clog2(CYC_PER_BIT * ROW_BITS + READ_CYC + 1);

   // elaboration checks
   if (ROW_WORDS != 1 && ROW_WORDS != 2) begin : g_bad_words
      $error("ROW_WORDS must be 1 or 2");
   end
   if (ROWS < 2 || ROWS > (1 << ROWADDR_W) || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two between 2 and 65536");
   end
   if (CYC_PER_BIT < 1 || READ_CYC < 1) begin : g_bad_cyc
      $error("CYC_PER_BIT and READ_CYC must be at least 1");
   end

   // software registers
   logic                 mode_q;
   logic [CMD_W-1:0]     cmd_q;
   logic [ROWADDR_W-1:0] addr_q;
   logic                 start_q;
   logic                 done_q;
   logic [ROW_BITS-1:0]  wd_flat;
   logic [ROW_BITS-1:0]  rd_flat;

   // captured operation
   logic [CMD_W-1:0]     op_cmd;
   logic [IDX_W-1:0]     op_row;
   logic [ROW_BITS-1:0]  op_data;

   logic                 busy, finish, perm;
   logic                 launch, start_wr, start_clr_wr;
   logic [CNT_W-1:0]     load_val;
   logic [POP_W-1:0]     pop_cnt;
   logic [ROW_BITS-1:0]  arr_rd;
   logic [ROWS*ROW_BITS-1:0] arr_all;
   logic                 fuse_wr;

   assign start_wr     = bus_we && (bus_addr == OFS_START);
   assign start_clr_wr = start_wr && !bus_wdata[0];
   assign launch       = start_wr && bus_wdata[0] && !start_q && mode_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         cmd_q   <= '0;
         addr_q  <= '0;
         start_q <= 1'b0;
      end else if (bus_we) begin
         unique case (bus_addr)
            OFS_MODE:  mode_q  <= bus_wdata[0];
            OFS_CMD:   cmd_q   <= bus_wdata[CMD_W-1:0];
            OFS_ADDR:  addr_q  <= bus_wdata[ROWADDR_W-1:0];
            OFS_START: start_q <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   for (genvar w = 0; w < ROW_WORDS; w++) begin : g_wd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wd_flat[w*WORD_W +: WORD_W] <= '0;
         else if (bus_we && (bus_addr == OFS_WD[w]))
            wd_flat[w*WORD_W +: WORD_W] <= bus_wdata;
      end
   end

   // launch latency: program time scales with set bits
   assign pop_cnt = POP_W'($countones(wd_flat));

   always_comb begin
      load_val = '0;
      if (cmd_q == OP_PROG && perm)
         load_val = CNT_W'(CYC_PER_BIT * pop_cnt);
      else if (cmd_q == OP_READ)
         load_val = CNT_W'(READ_CYC - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_cmd  <= '0;
         op_row  <= '0;
         op_data <= '0;
      end else if (launch) begin
         op_cmd  <= cmd_q;
         op_row  <= addr_q[IDX_W-1:0];
         op_data <= wd_flat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             done_q <= 1'b0;
      else if (finish)        done_q <= 1'b1;
      else if (launch)        done_q <= 1'b0;
      else if (start_clr_wr)  done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rd_flat <= '0;
      else if (finish && op_cmd == OP_READ) rd_flat <= arr_rd;
   end

   assign fuse_wr = finish && (op_cmd == OP_PROG) && perm;

   otp_op_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .load   (load_val),
      .busy   (busy),
      .finish (finish)
   );

   otp_key_tracker u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (finish && (op_cmd == OP_UNLOCK)),
      .clr_en  (finish && (op_cmd == OP_LOCK)),
      .key_in  (op_data[WORD_W-1:0]),
      .perm    (perm)
   );

   otp_fuse_array #(.ROWS(ROWS), .ROW_WORDS(ROW_WORDS)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fuse_wr),
      .wr_idx   (op_row),
      .wr_bits  (op_data),
      .rd_idx   (op_row),
      .rd_bits  (arr_rd),
      .all_bits (arr_all)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_MODE:   bus_rdata = {{(WORD_W-1){1'b0}}, mode_q};
         OFS_CMD:    bus_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
         OFS_START:  bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
         OFS_STATUS: bus_rdata = {{(WORD_W-3){1'b0}}, perm, done_q, 1'b0};
         OFS_ADDR:   bus_rdata = {{(WORD_W-ROWADDR_W){1'b0}}, addr_q};
         default: ;
      endcase
      for (int w = 0; w < ROW_WORDS; w++)
         if (bus_addr == OFS_RD[w]) bus_rdata = rd_flat[w*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
   parameter int ARR_BITS = 1024,
   parameter int IDX_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mode_en,
   input logic                busy,
   input logic                done,
   input logic                perm,
   input logic                finish,
   input logic                start_clr,
   input logic [5:0]          op_cmd,
   input logic [IDX_W-1:0]    op_row,
   input logic [ARR_BITS-1:0] arr
);

   p_done_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_clr && !finish) |=> !done);

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_en && !busy) |=> !busy);

   p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && op_cmd == 6'h03) |=> !perm);

   p_locked_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !perm |=> $stable(arr));

   p_fuse_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(arr) & ~arr) == '0));

   p_op_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(op_row) && $stable(op_cmd)));

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
   .ARR_BITS (ROWS * ROW_WORDS * 32),
   .IDX_W    ($clog2(ROWS))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_en   (mode_q),
   .busy      (busy),
   .done      (done_q),
   .perm      (perm),
   .finish    (finish),
   .start_clr (start_clr_wr),
   .op_cmd    (op_cmd),
   .op_row    (op_row),
   .arr       (arr_all)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;

   localparam int CPB   = 2;
   localparam int RDC   = 3;
   localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                          A_ST = 8'h0C, A_RD0 = 8'h10, A_ADDR = 8'h28,
                          A_WD0 = 8'h2C, A_RD1 = 8'h5C, A_WD1 = 8'h64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] model [16];

   always #10 clk = ~clk;

   otp_fuse_ctrl #(.ROWS(16), .ROW_WORDS(2), .CYC_PER_BIT(CPB), .READ_CYC(RDC)) dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // row, word0, word1
   localparam int NV = 6;
   localparam logic [67:0] VEC [NV] = '{
      {4'd2,  32'h0000_00F0, 32'h0000_0000},
      {4'd2,  32'h0000_000F, 32'h8000_0000},
      {4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {4'd0,  32'h0000_0000, 32'h0000_0000},
      {4'd2,  32'h0000_0010, 32'h0000_0000},
      {4'd15, 32'hA5A5_A5A5, 32'h0000_0300}
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // set start, count cycles until done is seen
   task automatic go(output int lat);
      logic [31:0] st;
      wr(A_START, 32'h1);
      lat = 0;
      rd(A_ST, st);
      while (!st[1] && lat < 5000) begin
         @(negedge clk);
         lat++;
         rd(A_ST, st);
      end
   endtask

   task automatic op(input logic [5:0] c, input logic [15:0] row,
                     input logic [31:0] w0, input logic [31:0] w1, output int lat);
      wr(A_CMD, {26'd0, c});
      wr(A_ADDR, {16'd0, row});
      wr(A_WD0, w0);
      wr(A_WD1, w1);
      go(lat);
      wr(A_START, 32'h0);
   endtask

   task automatic read_row(input logic [15:0] row, input string tag, input logic [63:0] exp);
      int lat;
      logic [31:0] r0, r1;
      op(6'h00, row, 32'h0, 32'h0, lat);
      chk(lat == RDC, {tag, " R9 read latency"}, 64'(lat), 64'(RDC));
      rd(A_RD0, r0);
      rd(A_RD1, r1);
      chk({r1, r0} == exp, {tag, " R9 R10 row data"}, {r1, r0}, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int lat;
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_ST, v);   chk(v == 0, "R1 status", v, 0);
      rd(A_MODE, v); chk(v == 0, "R1 mode", v, 0);
      rd(A_RD0, v);  chk(v == 0, "R1 rd0", v, 0);
      rd(A_RD1, v);  chk(v == 0, "R1 rd1", v, 0);

      // R2 mode clear: start ignored
      wr(A_CMD, 32'h0);
      wr(A_START, 32'h1);
      repeat (10) @(negedge clk);
      rd(A_ST, v); chk(v[1] == 1'b0, "R2 no done while mode off", v, 0);
      wr(A_START, 32'h0);
      wr(A_MODE, 32'h1);
      rd(A_MODE, v); chk(v == 1, "R2 mode set", v, 1);

      // R3 register widths
      wr(A_ADDR, 32'hABCD_1234);
      rd(A_ADDR, v); chk(v == 32'h1234, "R3 address width", v, 32'h1234);
      wr(A_CMD, 32'hFFFF_FFFF);
      rd(A_CMD, v); chk(v == 32'h3F, "R3 command width", v, 32'h3F);

      // R6 program without permission
      op(6'h08, 16'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, lat);
      chk(lat == 1, "R6 locked program latency", 64'(lat), 1);
      read_row(16'd1, "R6 locked row", 64'h0);

      // R5 bad sequence then good sequence
      op(6'h02, 0, 32'hF, 0, lat); chk(lat == 1, "R5 unlock step latency", 64'(lat), 1);
      op(6'h02, 0, 32'h4, 0, lat);
      op(6'h02, 0, 32'h7, 0, lat);
      op(6'h02, 0, 32'h8, 0, lat);
      op(6'h02, 0, 32'hD, 0, lat);
      rd(A_ST, v); chk(v[2] == 1'b0, "R5 wrong key stays locked", v, 0);
      op(6'h02, 0, 32'hF, 0, lat);
      op(6'h02, 0, 32'h4, 0, lat);
      op(6'h02, 0, 32'h8, 0, lat);
      rd(A_ST, v); chk(v[2] == 1'b0, "R5 locked before last key", v, 0);
      op(6'h02, 0, 32'hD, 0, lat);
      rd(A_ST, v); chk(v[2] == 1'b1, "R5 unlocked after key", v, 4);

      // table: program, check latency, read back
      for (int i = 0; i < NV; i++) begin
         logic [3:0]  row;
         logic [63:0] dat;
         int exp_lat;
         row = VEC[i][67:64];
         dat = {VEC[i][31:0], VEC[i][63:32]};
         exp_lat = 1 + CPB * $countones(dat);
         op(6'h08, {12'd0, row}, dat[31:0], dat[63:32], lat);
         chk(lat == exp_lat, $sformatf("R8 vec%0d program latency", i), 64'(lat), 64'(exp_lat));
         model[row] = model[row] | dat;
         read_row({12'd0, row}, $sformatf("R7 vec%0d", i), model[row]);
      end

      // R4 start written 1 while already 1 does not relaunch; clearing drops done
      wr(A_CMD, 32'h0);
      wr(A_START, 32'h1);
      repeat (RDC + 2) @(negedge clk);
      rd(A_ST, v); chk(v[1] == 1'b1, "R4 done after read", v, 2);
      wr(A_START, 32'h1);
      rd(A_ST, v); chk(v[1] == 1'b1, "R4 no relaunch on held start", v, 2);
      wr(A_START, 32'h0);
      rd(A_ST, v); chk(v[1] == 1'b0, "R4 done cleared with start", v, 0);

      // R11 writes during a running program, one on its completion edge
      wr(A_CMD, 32'h8);
      wr(A_ADDR, 32'd5);
      wr(A_WD0, 32'h3);
      wr(A_WD1, 32'h0);
      wr(A_START, 32'h1);            // launch edge E, latency 5
      wr(A_START, 32'h0);            // E+1
      wr(A_START, 32'h1);            // E+2, busy: no launch
      repeat (2) @(negedge clk);     // E+3, E+4
      wr(A_WD0, 32'hFFFF_0000);      // E+5, completion edge
      rd(A_ST, v); chk(v[1] == 1'b1, "R11 done at original latency", v, 2);
      wr(A_START, 32'h0);
      model[5] = 64'h3;
      read_row(16'd5, "R11 captured data", model[5]);

      // R6 lock clears permission, later program has no effect
      op(6'h03, 0, 0, 0, lat);
      chk(lat == 1, "R6 lock latency", 64'(lat), 1);
      rd(A_ST, v); chk(v[2] == 1'b0, "R6 permission dropped", v, 0);
      op(6'h08, 16'd7, 32'hFF, 32'h1, lat);
      chk(lat == 1, "R6 program after lock latency", 64'(lat), 1);
      read_row(16'd7, "R6 row after lock", 64'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule